// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers a set of interrupt request lines and picks one for the processor. Every source has a control register with a 3-bit priority level and a pending bit. Hardware sets the pending bit when the source's line is high. The pending bit is cleared when the processor acknowledges that source, or when software writes a 0 to it.

A source is eligible when three things hold: the global enable flag is 1, its pending bit is set, and its level is strictly above the processor priority level input. Among eligible sources, the highest level wins. The selection is registered and held until the processor acknowledges it.

A separate wake register holds a threshold. Any pending source whose level is above that threshold raises a wake output, so the core can leave a stop or wait state. The wake register also holds a bit that marks level-7 selections as fast interrupts.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous reset, the following are all 0: the global enable flag, every control register, the wake register, irq_valid, irq_fast, irq_wake and reg_rdata.
- R2: While irq_in[i] is high at a clock edge, the pending bit of source i (control register bit 3) is 1 after that edge.
- R3: A register write with bit 3 = 0 to control register i clears its pending bit. A write with bit 3 = 1 leaves the pending bit unchanged, so it cannot create a request. The write stores bits 2..0 as the level (binary, 000 = level 0 to 111 = level 7).
- R4: If a hardware set meets a software clear or an acknowledge clear of the same pending bit in one cycle, the bit ends up 1.
- R5: A source is selected only when the enable flag (register N+1, bit 0) is 1 and its level is strictly greater than ipl_in. A level-0 source is never selected.
- R6: Among eligible sources, the highest level is chosen. On equal levels, the lowest index is chosen.
- R7: When irq_valid is low, the selection is loaded at each edge, so a result appears one cycle after the eligibility it reflects. While irq_valid is high and irq_ack is low, irq_valid, irq_idx and irq_lvl hold their values, even if ipl_in or the enable flag change.
- R8: irq_ack while irq_valid is high clears the pending bit of the selected source in that cycle. irq_valid is low in the next cycle, and selection resumes one cycle later.
- R9: irq_wake is 1 one cycle after any pending source has a level strictly greater than the wake threshold (wake register bits 2..0). This does not depend on the enable flag or on ipl_in.
- R10: irq_fast is 1 exactly when a selection is loaded at level 7 while the fast bit (wake register bit 3) is 1. It drops together with irq_valid.
- R11: Register map:
  - Address i < N reads {0000, pending, level}.
  - Address N reads {0000, fast, threshold}.
  - Address N+1 reads {0000000, enable}.
  - reg_rdata is registered and shows the register at reg_addr one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N | Request lines, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Registered read data |
| ipl_in | input | 3 | Current processor priority level |
| irq_ack | input | 1 | Acknowledge of the presented source |
| irq_valid | output | 1 | A selected source is presented |
| irq_idx | output | IDX_W | Index of the selected source |
| irq_lvl | output | 3 | Level of the selected source |
| irq_fast | output | 1 | Selected source uses the fast path |
| irq_wake | output | 1 | Wake request for stop/wait exit |

## Verification
The hardest case to reach is a hardware set landing in the same cycle as a clear of the same pending bit, whether the clear comes from software or from an acknowledge. Random stimulus rarely lines up a request pulse, a write to that exact register and an acknowledge of that exact source. A directed step therefore issues the request and a clearing write in one cycle and reads the register back. The random phase keeps acknowledges frequent and request pulses dense, so acknowledge/set collisions also occur. The hold behaviour under a changing processor level is also forced directly: the level is raised above a presented selection before it is acknowledged.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int LVL_W   = 3;
  localparam int LVL_MAX = (1 << LVL_W) - 1;
  localparam int PEND_BIT = 3;   // pending bit in control registers
  localparam int FAST_BIT = 3;   // fast-select bit in wake register
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_prio_pkg::*;
#(
  parameter int N      = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      irq_in,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        wdata,
  input  logic [N-1:0]      ack_clr,
  output logic [N-1:0]      pend,
  output lvl_t [N-1:0]      lvl
);
  for (genvar g = 0; g < N; g++) begin : g_src
    logic wsel;
    assign wsel = we && (addr == ADDR_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        lvl[g]  <= '0;
        pend[g] <= 1'b0;
      end else begin
        if (wsel) lvl[g] <= wdata[LVL_W-1:0];
        if (irq_in[g]) pend[g] <= 1'b1;
        else if ((wsel && !wdata[PEND_BIT]) || ack_clr[g]) pend[g] <= 1'b0;
      end
    end

    p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
      irq_in[g] |=> pend[g]);
    p_no_sw_set_r3: assert property (@(posedge clk) disable iff (rst)
      (!pend[g] && !irq_in[g]) |=> !pend[g]);
    p_ack_clear_r8: assert property (@(posedge clk) disable iff (rst)
      (ack_clr[g] && !irq_in[g]) |=> !pend[g]);
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_prio_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     pend,
  input  lvl_t [N-1:0]     lvl,
  input  logic             en,
  input  lvl_t             ipl,
  output logic             found,
  output logic [IDX_W-1:0] best_idx,
  output lvl_t             best_lvl
);
  // Strict '>' on replacement keeps the lowest index on ties.
  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_lvl = '0;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && en && (lvl[i] > ipl) && (!found || lvl[i] > best_lvl)) begin
        found    = 1'b1;
        best_idx = IDX_W'(i);
        best_lvl = lvl[i];
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int N      = 8,
  parameter int DW     = 8,
  parameter int ADDR_W = $clog2(N + 2),
  parameter int IDX_W  = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      irq_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [2:0]        ipl_in,
  input  logic              irq_ack,
  output logic              irq_valid,
  output logic [IDX_W-1:0]  irq_idx,
  output logic [2:0]        irq_lvl,
  output logic              irq_fast,
  output logic              irq_wake
);
  localparam logic [ADDR_W-1:0] A_WAKE = ADDR_W'(N);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(N + 1);

  logic [N-1:0]     pend;
  lvl_t [N-1:0]     lvl;
  logic [N-1:0]     ack_clr;
  logic [N-1:0]     above_thr;
  logic             found;
  logic [IDX_W-1:0] best_idx;
  lvl_t             best_lvl;
  lvl_t             thr_q;
  logic             fast_en_q;
  logic             en_q;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata[DW-1:4];
  assign ack_clr = (irq_ack && irq_valid) ? (N'(1) << irq_idx) : '0;

  irq_src_bank #(.N(N), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst(rst), .irq_in(irq_in), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata[3:0]), .ack_clr(ack_clr), .pend(pend), .lvl(lvl)
  );

  irq_arbiter #(.N(N), .IDX_W(IDX_W)) u_arb (
    .pend(pend), .lvl(lvl), .en(en_q), .ipl(ipl_in),
    .found(found), .best_idx(best_idx), .best_lvl(best_lvl)
  );

  // Wake / fast-select register and global enable flag
  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q     <= '0;
      fast_en_q <= 1'b0;
      en_q      <= 1'b0;
    end else if (reg_we) begin
      if (reg_addr == A_WAKE) begin
        thr_q     <= reg_wdata[LVL_W-1:0];
        fast_en_q <= reg_wdata[FAST_BIT];
      end
      if (reg_addr == A_EN) en_q <= reg_wdata[0];
    end
  end

  // Registered selection, held until acknowledged
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid <= 1'b0;
      irq_idx   <= '0;
      irq_lvl   <= '0;
      irq_fast  <= 1'b0;
    end else if (irq_valid) begin
      if (irq_ack) begin
        irq_valid <= 1'b0;
        irq_fast  <= 1'b0;
      end
    end else begin
      irq_valid <= found;
      irq_idx   <= best_idx;
      irq_lvl   <= best_lvl;
      irq_fast  <= found && (best_lvl == lvl_t'(LVL_MAX)) && fast_en_q;
    end
  end

  // Wake request
  always_comb begin
    for (int i = 0; i < N; i++) above_thr[i] = pend[i] && (lvl[i] > thr_q);
  end

  always_ff @(posedge clk) begin
    if (rst) irq_wake <= 1'b0;
    else     irq_wake <= |above_thr;
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      if (reg_addr < A_WAKE)
        reg_rdata[3:0] <= {pend[reg_addr[IDX_W-1:0]], lvl[reg_addr[IDX_W-1:0]]};
      else if (reg_addr == A_WAKE)
        reg_rdata[3:0] <= {fast_en_q, thr_q};
      else if (reg_addr == A_EN)
        reg_rdata[0] <= en_q;
    end
  end

  p_accept_gt_ipl_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_valid) |-> (irq_lvl > $past(ipl_in)));
  p_accept_en_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_valid) |-> $past(en_q));
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && !irq_ack) |=> (irq_valid && $stable(irq_idx) && $stable(irq_lvl)));
  p_drop_after_ack_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && irq_ack) |=> !irq_valid);
  p_fast_lvl7_r10: assert property (@(posedge clk) disable iff (rst)
    irq_fast |-> (irq_valid && irq_lvl == 3'd7));
endmodule

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;
  localparam int N = 8;
  localparam int DW = 8;
  localparam int AW = $clog2(N + 2);
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] irq_in = '0;
  logic reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [2:0] ipl_in = '0;
  logic irq_ack = 1'b0;
  logic irq_valid, irq_fast, irq_wake;
  logic [IW-1:0] irq_idx;
  logic [2:0] irq_lvl;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_prio_ctrl #(.N(N), .DW(DW)) uut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ipl_in(ipl_in), .irq_ack(irq_ack),
    .irq_valid(irq_valid), .irq_idx(irq_idx), .irq_lvl(irq_lvl),
    .irq_fast(irq_fast), .irq_wake(irq_wake)
  );

  // Reference state
  logic [2:0] m_lvl [N];
  logic       m_pend [N];
  logic [2:0] m_thr;
  logic m_fast, m_en, m_valid, m_ofast, m_wake;
  logic [IW-1:0] m_idx;
  logic [2:0] m_olvl;
  logic [DW-1:0] m_rdata;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Highest level first, lowest index within a level
  task automatic pick(output logic f, output logic [IW-1:0] idx, output logic [2:0] l);
    f = 1'b0; idx = '0; l = '0;
    for (int lv = 7; lv >= 0; lv--) begin
      for (int i = 0; i < N; i++) begin
        if (!f && m_en && m_pend[i] && m_lvl[i] == 3'(lv) && 3'(lv) > ipl_in) begin
          f = 1'b1; idx = IW'(i); l = 3'(lv);
        end
      end
    end
  endtask

  task automatic tick();
    logic n_pend [N];
    logic [2:0] n_lvl [N];
    logic [2:0] n_thr;
    logic n_fast, n_en, n_valid, n_ofast, n_wake, f;
    logic [IW-1:0] n_idx, bi;
    logic [2:0] n_olvl, bl;
    logic [DW-1:0] n_rd;
    n_thr = m_thr; n_fast = m_fast; n_en = m_en;
    n_valid = m_valid; n_idx = m_idx; n_olvl = m_olvl; n_ofast = m_ofast;
    n_wake = 1'b0;
    for (int i = 0; i < N; i++) begin
      n_lvl[i] = m_lvl[i]; n_pend[i] = m_pend[i];
      if (m_pend[i] && m_lvl[i] > m_thr) n_wake = 1'b1;
      if (reg_we && reg_addr == AW'(i)) n_lvl[i] = reg_wdata[2:0];
      if (irq_in[i]) n_pend[i] = 1'b1;
      else if ((reg_we && reg_addr == AW'(i) && !reg_wdata[3]) ||
               (irq_ack && m_valid && m_idx == IW'(i))) n_pend[i] = 1'b0;
    end
    if (reg_we && reg_addr == AW'(N)) begin n_thr = reg_wdata[2:0]; n_fast = reg_wdata[3]; end
    if (reg_we && reg_addr == AW'(N + 1)) n_en = reg_wdata[0];
    if (m_valid) begin
      if (irq_ack) begin n_valid = 1'b0; n_ofast = 1'b0; end
    end else begin
      pick(f, bi, bl);
      n_valid = f; n_idx = bi; n_olvl = bl; n_ofast = f && bl == 3'd7 && m_fast;
    end
    n_rd = '0;
    if (reg_addr < AW'(N)) n_rd = {4'b0, m_pend[reg_addr[IW-1:0]], m_lvl[reg_addr[IW-1:0]]};
    else if (reg_addr == AW'(N)) n_rd = {4'b0, m_fast, m_thr};
    else if (reg_addr == AW'(N + 1)) n_rd = {7'b0, m_en};
    if (rst) begin
      for (int i = 0; i < N; i++) begin n_lvl[i] = '0; n_pend[i] = 1'b0; end
      n_thr = '0; n_fast = 0; n_en = 0; n_valid = 0; n_ofast = 0; n_wake = 0;
      n_rd = '0; n_idx = '0; n_olvl = '0;
    end
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin m_lvl[i] = n_lvl[i]; m_pend[i] = n_pend[i]; end
    m_thr = n_thr; m_fast = n_fast; m_en = n_en; m_valid = n_valid; m_idx = n_idx;
    m_olvl = n_olvl; m_ofast = n_ofast; m_wake = n_wake; m_rdata = n_rd;
    irq_in = '0; reg_we = 1'b0; irq_ack = 1'b0;
    check(irq_valid === m_valid, "R6 valid", irq_valid, m_valid);
    if (m_valid) begin
      check(irq_idx === m_idx, "R6 index", irq_idx, m_idx);
      check(irq_lvl === m_olvl, "R6 level", irq_lvl, m_olvl);
    end
    check(irq_fast === m_ofast, "R10 fast", irq_fast, m_ofast);
    check(irq_wake === m_wake, "R9 wake", irq_wake, m_wake);
    check(reg_rdata === m_rdata, "R11 rdata", reg_rdata, m_rdata);
  endtask

  task automatic wr(input int a, input int d);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = DW'(d);
    tick();
  endtask

  task automatic rd(input int a, output logic [DW-1:0] v);
    reg_addr = AW'(a);
    tick();
    v = reg_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", checks, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    int seed;
    seed = $urandom(32'd2024);
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1: reset state
    check(irq_valid === 1'b0 && irq_wake === 1'b0 && irq_fast === 1'b0, "R1 outputs",
          {irq_valid, irq_wake, irq_fast}, 0);
    for (int a = 0; a < N + 2; a++) begin
      rd(a, v);
      check(v === '0, "R1 register", v, 0);
    end
    // R6: equal levels, lowest index wins; R2 pending set
    wr(N + 1, 1);
    ipl_in = 3'd0;
    wr(2, 4); wr(5, 4); wr(1, 0);
    irq_in = 8'b0010_0110; tick();
    tick();
    check(irq_valid && irq_idx == 2 && irq_lvl == 4, "R6 tie", irq_idx, 2);
    rd(5, v);
    check(v[3] === 1'b1, "R2 pending", v, 8'h0C);
    // R8: ack clears and drops valid
    irq_ack = 1'b1; tick();
    check(irq_valid === 1'b0, "R8 drop", irq_valid, 0);
    tick();
    check(irq_valid && irq_idx == 5, "R8 reselect", irq_idx, 5);
    irq_ack = 1'b1; tick();
    tick(); tick();
    check(irq_valid === 1'b0, "R5 level0 never", irq_valid, 0);
    // R5: equal level not accepted
    ipl_in = 3'd3;
    wr(3, 3); irq_in[3] = 1'b1; tick(); tick(); tick();
    check(irq_valid === 1'b0, "R5 equal ipl", irq_valid, 0);
    ipl_in = 3'd2; tick(); tick();
    check(irq_valid && irq_idx == 3, "R5 above ipl", irq_idx, 3);
    irq_ack = 1'b1; tick();
    // R3: writing 1 to pending bit does not set it
    wr(4, 8'h0F);
    rd(4, v);
    check(v === 8'h07, "R3 no sw set", v, 8'h07);
    // R4: hardware set beats software clear
    irq_in[4] = 1'b1; reg_we = 1'b1; reg_addr = AW'(4); reg_wdata = 8'h07; tick();
    rd(4, v);
    check(v === 8'h0F, "R4 set wins", v, 8'h0F);
    tick();
    irq_ack = 1'b1; tick();
    // R10: fast selection at level 7
    wr(N, 8'h08);
    irq_in[4] = 1'b1; tick(); tick();
    check(irq_fast === 1'b1 && irq_lvl == 7, "R10 fast", irq_fast, 1);
    irq_ack = 1'b1; tick();
    check(irq_fast === 1'b0, "R10 fast drop", irq_fast, 0);
    // R9: wake threshold, independent of enable
    wr(N + 1, 0);
    wr(N, 8'h0B);
    wr(6, 3); irq_in[6] = 1'b1; tick(); tick();
    check(irq_wake === 1'b0, "R9 wake at threshold", irq_wake, 0);
    wr(N, 8'h0A); tick();
    check(irq_wake === 1'b1, "R9 wake above", irq_wake, 1);
    check(irq_valid === 1'b0, "R5 disabled", irq_valid, 0);
    // R7: hold while ipl rises
    ipl_in = 3'd0;
    wr(N + 1, 1); tick();
    check(irq_valid && irq_idx == 6, "R7 load", irq_idx, 6);
    ipl_in = 3'd7; tick(); tick();
    check(irq_valid && irq_idx == 6 && irq_lvl == 3, "R7 hold", irq_idx, 6);
    irq_ack = 1'b1; tick();
    // Random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 4 == 0) irq_in = N'($urandom) & N'($urandom);
      if ($urandom % 5 == 0) begin
        reg_we = 1'b1;
        reg_addr = AW'($urandom % (N + 2));
        reg_wdata = DW'($urandom);
        if (reg_addr == AW'(N + 1)) reg_wdata[0] = ($urandom % 4 != 0);
      end else begin
        reg_addr = AW'($urandom % (N + 2));
      end
      if ($urandom % 8 == 0) ipl_in = 3'($urandom % 5);
      irq_ack = ($urandom % 3 == 0);
      tick();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule